// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. Once reset is released, it keeps the command pins in a quiet state for a programmable settling pause. During that time it issues only no-operation cycles, with clock-enable and the data masks held high. It then closes every bank with one precharge-all command. After that come a fixed number of auto-refresh commands, spaced by the row cycle time, and one mode register load. The load word is assembled from the configuration inputs. When the mode-load recovery time has run out, the block raises a done flag. The memory controller that owns the bus afterwards waits for this flag before taking over the pins.

Every wait is a parameter counted in clock cycles. Every cycle that is not a command cycle carries a no-operation command. All pins come from registered state. Reset may be asserted at any point and always restarts the sequence from the pause. The pins have no flow control: the SDRAM samples them on every edge, so there is no back-pressure. The configuration inputs are plain levels and must be stable while the mode load is presented.

Top module: `sdr_init_seq`

## Requirements
- R1: While rst_n is low, and after release until the precharge appears, the pins carry NOP: cs_n=0 and ras_n=cas_n=we_n=1, with sd_addr=0, sd_ba=0 and init_done=0. The precharge is presented after the PAUSE_CYC-th rising edge following release.
- R2: sd_cke=1 and every bit of sd_dqm=1 in every cycle, both in reset and outside it.
- R3: Exactly one precharge-all is issued per run, encoded cs_n=0, ras_n=0, cas_n=1, we_n=0, with sd_addr bit 10 set, all other address bits 0 and sd_ba=0.
- R4: The first auto-refresh is presented TRP_CYC rising edges after the precharge. It is encoded cs_n=0, ras_n=0, cas_n=0, we_n=1, with sd_addr=0 and sd_ba=0.
- R5: REF_NUM auto-refreshes (default 8) are issued, each TRC_CYC rising edges after the one before.
- R6: The mode load is presented TRC_CYC rising edges after the last refresh and follows the last refresh only. It is encoded with cs_n, ras_n, cas_n and we_n all 0, and sd_ba=0.
- R7: During the mode load, sd_addr[2:0] carries cfg_burst_len, bit 3 carries cfg_interleave, bits [6:4] carry cfg_cas_lat and bit 9 carries cfg_single_write. Bits 7, 8 and all bits from 10 upward are 0.
- R8: Every cycle between commands carries NOP with sd_addr=0 and sd_ba=0.
- R9: init_done rises TRSC_CYC rising edges after the mode load. It then stays high until reset, and only NOP follows.
- R10: A reset asserted at any point in the sequence returns the pins to the R1 state. After release the whole sequence repeats from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, restarts the sequence |
| cfg_burst_len | input | 3 | Burst length code placed in mode word bits [2:0] |
| cfg_interleave | input | 1 | Burst order (1 = interleaved), mode word bit 3 |
| cfg_cas_lat | input | 3 | Read latency code (010 = 2, 011 = 3), mode word bits [6:4] |
| cfg_single_write | input | 1 | 1 = single-word writes, mode word bit 9 |
| sd_cke | output | 1 | Clock enable to the SDRAM |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Multiplexed address / mode word |
| sd_dqm | output | DQM_W | Byte data masks |
| init_done | output | 1 | Sequence complete, bus may be handed over |

## Verification
Each pin value is decoded from state registers that update on the rising edge, so a command is visible in the cycle after the edge that scheduled it. The bench therefore samples on the falling edge and numbers its samples from the first rising edge after reset release. From the parameters it derives the sample index at which the precharge, each refresh, the mode load and the first high init_done must appear. It then compares every sampled cycle against that schedule, so a command that arrives one cycle early or late fails. Reset values are read on the falling edges while rst_n is low, and the restart cases rerun the complete schedule from index zero.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [2:0] {
    PH_PAUSE,
    PH_PRECH,
    PH_REFR,
    PH_MODE,
    PH_DONE
  } phase_t;

  // Command codes as {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_PRECH = 4'b0010;
  localparam logic [3:0] CMD_REFR  = 4'b0001;
  localparam logic [3:0] CMD_MODE  = 4'b0000;

  // Address bit that selects every bank on a precharge
  localparam int ALLBANK_BIT = 10;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_init_ctrl.sv
module sdr_init_ctrl
  import sdr_init_pkg::*;
#(
  parameter int TRP_CYC  = 4,
  parameter int TRC_CYC  = 14,
  parameter int TRSC_CYC = 2,
  parameter int REF_NUM  = 8,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  output phase_t           phase,
  output logic             issue,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam int REF_W = (REF_NUM > 1) ? $clog2(REF_NUM) : 1;

  phase_t           phase_q, phase_nx;
  logic             issue_q;
  logic [REF_W-1:0] ref_q;
  logic [CNT_W-1:0] gap;
  logic             last_ref;
  logic             advance;

  assign last_ref = (ref_q == REF_W'(REF_NUM - 1));

  always_comb begin
    case (phase_q)
      PH_PRECH: gap = CNT_W'(TRP_CYC);
      PH_REFR:  gap = CNT_W'(TRC_CYC);
      PH_MODE:  gap = CNT_W'(TRSC_CYC);
      default:  gap = CNT_W'(1);
    endcase

    case (phase_q)
      PH_PAUSE: phase_nx = PH_PRECH;
      PH_PRECH: phase_nx = PH_REFR;
      PH_REFR:  phase_nx = last_ref ? PH_MODE : PH_REFR;
      PH_MODE:  phase_nx = PH_DONE;
      default:  phase_nx = PH_DONE;
    endcase

    // A command cycle moves on at once when its gap is one edge;
    // otherwise the wait ends when the shared timer runs out.
    if (issue_q) advance = (gap <= CNT_W'(1));
    else         advance = expired && (phase_q != PH_DONE);

    tmr_load = issue_q && (gap > CNT_W'(1));
    tmr_val  = gap - CNT_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      issue_q <= 1'b0;
      ref_q   <= '0;
    end else begin
      issue_q <= advance && (phase_nx != PH_DONE);
      if (advance) begin
        phase_q <= phase_nx;
        if (phase_q == PH_REFR) ref_q <= ref_q + 1'b1;
      end
    end
  end

  assign phase = phase_q;
  assign issue = issue_q;

endmodule

// File: rtl/sdr_pin_encode.sv
module sdr_pin_encode
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 1,
  parameter int DQM_W  = 2
) (
  input  phase_t            phase,
  input  logic              issue,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_single_write,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              ready
);

  localparam int MW_W = 10;

  logic [MW_W-1:0]   mode_low;
  logic [ADDR_W-1:0] mode_word;
  logic [ADDR_W-1:0] prech_word;
  logic [3:0]        cmd;

  assign mode_low = {cfg_single_write, 2'b00, cfg_cas_lat, cfg_interleave, cfg_burst_len};

  generate
    if (ADDR_W > MW_W) begin : g_pad
      assign mode_word = {{(ADDR_W - MW_W){1'b0}}, mode_low};
    end else begin : g_exact
      assign mode_word = mode_low[ADDR_W-1:0];
    end
  endgenerate

  assign prech_word = ADDR_W'(1) << ALLBANK_BIT;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    if (issue) begin
      case (phase)
        PH_PRECH: begin cmd = CMD_PRECH; addr = prech_word; end
        PH_REFR:  begin cmd = CMD_REFR; end
        PH_MODE:  begin cmd = CMD_MODE;  addr = mode_word;  end
        default:  cmd = CMD_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba    = '0;
  assign cke   = 1'b1;
  assign dqm   = '1;
  assign ready = (phase == PH_DONE);

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_init_pkg::*;
#(
  parameter int PAUSE_CYC = 40000,
  parameter int TRP_CYC   = 4,
  parameter int TRC_CYC   = 14,
  parameter int TRSC_CYC  = 2,
  parameter int REF_NUM   = 8,
  parameter int ADDR_W    = 11,
  parameter int BA_W      = 1,
  parameter int DQM_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_single_write,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int MAX_WAIT = max_of4(PAUSE_CYC, TRP_CYC, TRC_CYC, TRSC_CYC);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  phase_t           phase;
  logic             issue;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             expired;

  sdr_gap_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PAUSE_CYC - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (expired)
  );

  sdr_init_ctrl #(
    .TRP_CYC (TRP_CYC),
    .TRC_CYC (TRC_CYC),
    .TRSC_CYC(TRSC_CYC),
    .REF_NUM (REF_NUM),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .expired (expired),
    .phase   (phase),
    .issue   (issue),
    .tmr_load(tmr_load),
    .tmr_val (tmr_val)
  );

  sdr_pin_encode #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W),
    .DQM_W (DQM_W)
  ) u_enc (
    .phase           (phase),
    .issue           (issue),
    .cfg_burst_len   (cfg_burst_len),
    .cfg_interleave  (cfg_interleave),
    .cfg_cas_lat     (cfg_cas_lat),
    .cfg_single_write(cfg_single_write),
    .cke             (sd_cke),
    .cs_n            (sd_cs_n),
    .ras_n           (sd_ras_n),
    .cas_n           (sd_cas_n),
    .we_n            (sd_we_n),
    .ba              (sd_ba),
    .addr            (sd_addr),
    .dqm             (sd_dqm),
    .ready           (init_done)
  );

endmodule

// File: rtl/sdr_init_chk.sv
module sdr_init_chk
  import sdr_init_pkg::*;
#(
  parameter int PAUSE_CYC = 40000,
  parameter int TRP_CYC   = 4,
  parameter int TRC_CYC   = 14,
  parameter int TRSC_CYC  = 2,
  parameter int REF_NUM   = 8,
  parameter int ADDR_W    = 11,
  parameter int BA_W      = 1,
  parameter int DQM_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done
);

  logic [3:0]  cmd, last_q;
  logic [31:0] since_q;
  logic [15:0] n_pre_q, n_ref_q;
  logic        is_cmd, is_pre, is_ref, is_mode;

  assign cmd     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_cmd  = (cmd != CMD_NOP);
  assign is_pre  = (cmd == CMD_PRECH);
  assign is_ref  = (cmd == CMD_REFR);
  assign is_mode = (cmd == CMD_MODE);

  // Edges since the start of the last command cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      last_q  <= CMD_NOP;
      n_pre_q <= '0;
      n_ref_q <= '0;
    end else begin
      if (is_cmd) begin
        since_q <= 32'd1;
        last_q  <= cmd;
      end else if (since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
      if (is_pre) n_pre_q <= n_pre_q + 1'b1;
      if (is_ref) n_ref_q <= n_ref_q + 1'b1;
    end
  end

  AST_PAUSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_q >= 32'(PAUSE_CYC)));                                 // R1
  AST_PINS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke && (&sd_dqm));                                                    // R2
  AST_PRE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (sd_addr == (ADDR_W'(1) << ALLBANK_BIT)) && (sd_ba == '0));  // R3
  AST_PRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (n_pre_q == '0));                                             // R3
  AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_q == CMD_PRECH) |-> (since_q >= 32'(TRP_CYC)));          // R4
  AST_REF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (sd_addr == '0) && (sd_ba == '0));                            // R4
  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_q == CMD_REFR) |-> (since_q >= 32'(TRC_CYC)));           // R5
  AST_MODE_AFTER_REFS: assert property (@(posedge clk) disable iff (!rst_n)
    is_mode |-> (n_ref_q == 16'(REF_NUM)) && (since_q >= 32'(TRC_CYC)));     // R6
  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (last_q == CMD_MODE) && (since_q >= 32'(TRSC_CYC))); // R9
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);                                                // R9
  AST_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !is_cmd);                                                  // R9

endmodule

bind sdr_init_seq sdr_init_chk #(
  .PAUSE_CYC(PAUSE_CYC),
  .TRP_CYC  (TRP_CYC),
  .TRC_CYC  (TRC_CYC),
  .TRSC_CYC (TRSC_CYC),
  .REF_NUM  (REF_NUM),
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .DQM_W    (DQM_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sd_cke   (sd_cke),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_ba    (sd_ba),
  .sd_addr  (sd_addr),
  .sd_dqm   (sd_dqm),
  .init_done(init_done)
);

// File: tb/sim_sdr_init_seq.sv
`timescale 1ns/1ps
module sim_sdr_init_seq;

  localparam int P    = 20;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TRSC = 2;
  localparam int NREF = 8;

  localparam int S_PRE  = P - 1;
  localparam int S_REF0 = S_PRE + TRP;
  localparam int S_MODE = S_REF0 + NREF * TRC;
  localparam int S_RDY  = S_MODE + TRSC;
  localparam int S_END  = S_RDY + 10;

  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MODE = 4'b0000;

  // {burst_len[2:0], interleave, cas_lat[2:0], single_write, expected mode word[10:0]}
  localparam int NVEC = 4;
  localparam logic [18:0] VEC [NVEC] = '{
    {3'b010, 1'b0, 3'b010, 1'b0, 11'h022},
    {3'b011, 1'b1, 3'b011, 1'b1, 11'h23B},
    {3'b111, 1'b0, 3'b010, 1'b0, 11'h027},
    {3'b000, 1'b1, 3'b011, 1'b1, 11'h238}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_bl = 3'b0;
  logic        cfg_il = 1'b0;
  logic [2:0]  cfg_cl = 3'b010;
  logic        cfg_sw = 1'b0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [0:0]  sd_ba;
  logic [10:0] sd_addr;
  logic [1:0]  sd_dqm;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdr_init_seq #(
    .PAUSE_CYC(P), .TRP_CYC(TRP), .TRC_CYC(TRC), .TRSC_CYC(TRSC), .REF_NUM(NREF),
    .ADDR_W(11), .BA_W(1), .DQM_W(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_il),
    .cfg_cas_lat(cfg_cl), .cfg_single_write(cfg_sw),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int s);
    if (s == S_PRE)  return C_PRE;
    if (s == S_MODE) return C_MODE;
    for (int k = 0; k < NREF; k++)
      if (s == S_REF0 + k * TRC) return C_REF;
    return C_NOP;
  endfunction

  function automatic string tag_of(input int s);
    logic [3:0] c;
    c = exp_cmd(s);
    if (c == C_PRE)  return "R3";
    if (c == C_MODE) return "R6";
    if (c == C_REF)  return (s == S_REF0) ? "R4" : "R5";
    if (s < S_PRE)   return "R1";
    if (s > S_MODE)  return "R9";
    return "R8";
  endfunction

  // Holds reset for three falling edges, checking the quiet state, then releases.
  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, req, "reset cmd",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
      check(sd_addr == 0 && sd_ba == 0, req, "reset addr", sd_addr, 0);
      check(init_done == 1'b0, req, "reset done", init_done, 0);
      check(sd_cke && sd_dqm == 2'b11, "R2", "reset cke/dqm", {sd_cke, sd_dqm}, 3'b111);
    end
    rst_n = 1'b1;
  endtask

  // Sample s is the falling edge after the (s+1)-th rising edge since release.
  task automatic run_seq(input logic [10:0] mode_exp, input int upto);
    for (int s = 0; s <= upto; s++) begin
      logic [3:0]  c, ec;
      logic [10:0] ea;
      string       t;
      @(negedge clk);
      c  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      ec = exp_cmd(s);
      t  = tag_of(s);
      ea = (ec == C_PRE) ? 11'h400 : (ec == C_MODE) ? mode_exp : 11'h000;
      check(c == ec, t, $sformatf("cmd at sample %0d", s), c, ec);
      check(sd_addr == ea, (ec == C_MODE) ? "R7" : t, $sformatf("addr at sample %0d", s), sd_addr, ea);
      check(sd_ba == 0, t, "bank", sd_ba, 0);
      check(sd_cke && sd_dqm == 2'b11, "R2", "cke/dqm", {sd_cke, sd_dqm}, 3'b111);
      check(init_done == (s >= S_RDY), "R9", $sformatf("done at sample %0d", s), init_done, s >= S_RDY);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=sequence end");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: state during the initial reset
    @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "power-on cmd",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    check(init_done == 1'b0, "R1", "power-on done", init_done, 0);

    // Table walk: one full sequence per mode configuration (R3..R9, R7 mode word)
    for (int i = 0; i < NVEC; i++) begin
      {cfg_bl, cfg_il, cfg_cl, cfg_sw} = VEC[i][18:11];
      do_reset("R1");
      run_seq(VEC[i][10:0], S_END);
    end

    // R10: reset in the middle of the refresh train restarts from the pause
    {cfg_bl, cfg_il, cfg_cl, cfg_sw} = VEC[1][18:11];
    do_reset("R1");
    run_seq(VEC[1][10:0], S_REF0 + 3 * TRC);
    do_reset("R10");
    run_seq(VEC[1][10:0], S_END);

    // R10: reset during the pause
    do_reset("R1");
    run_seq(VEC[1][10:0], 5);
    do_reset("R10");
    run_seq(VEC[1][10:0], S_END);

    // R10: reset after done clears it and repeats the sequence
    do_reset("R10");
    run_seq(VEC[0][10:0] & 11'h000 | VEC[1][10:0], S_END);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule